// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the first two doublewords of a PCI function's configuration header: the fixed identifier doubleword and the command/status doubleword. The bus interface logic reaches it through a single-cycle configuration port. The port carries a dword offset, four byte enables and 32-bit write data. Read data is a combinational function of the offset and the stored state, so the bus logic samples it in the same cycle it presents the offset.

Only ten bits of state exist: four writable command enables and six sticky error flags. Every other bit is a constant. The bus logic raises single-cycle error-set pulses when it detects parity errors, aborts or system errors, and software clears each flag by writing a one to it. The four command enables leave the block as plain level outputs that gate master, memory, parity and SERR behaviour elsewhere in the device.

Top module: `pcicfg_hdr`

## Requirements
- R1: A read of offset 0 returns 32'h6003_1013, with the device identifier in bits 31:16 and the vendor identifier in bits 15:0.
- R2: After reset, offset 1 reads 32'h0210_0000, meaning command 16'h0000 and status 16'h0210, and all four enable outputs are 0.
- R3: Status bits 10:9 (dword bits 26:25) always read 01, status bit 4 (dword bit 20) always reads 1, and status bits 7:5 and 3:0 always read 0, whatever is written.
- R4: Status error flags 15, 14, 13, 12, 11 and 8 (dword bits 31:27 and 24, all in byte lane 3) are write-one-to-clear. A written 1 clears the flag and a written 0 leaves it as it was.
- R5: Input err_set maps bit 5 to status 15, bit 4 to 14, bit 3 to 13, bit 2 to 12, bit 1 to 11 and bit 0 to 8. A pulse sets its flag from the next cycle on. A set in the same cycle as a clear of the same flag wins.
- R6: Command bits 8 (en_serr), 6 (en_perr), 2 (en_master) and 1 (en_mem) are read/write and appear on their outputs from the cycle after the write.
- R7: All other command bits (15:9, 7, 5:3, 0) read 0 even after all ones are written.
- R8: Each byte lane changes only when its byte enable is set. Command bits 6, 2 and 1 need cfg_be[0], command bit 8 needs cfg_be[1], and the error flags need cfg_be[3].
- R9: Offsets other than 0 and 1 read as zero, and writes to them change no state.
- R10: Writes to offset 0 change neither its value nor the command/status state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W | Dword offset |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| err_set | input | 6 | Error-set pulses from the bus logic |
| en_serr | output | 1 | SERR reporting enabled |
| en_perr | output | 1 | Parity error response enabled |
| en_master | output | 1 | Bus mastering enabled |
| en_mem | output | 1 | Memory space decoding enabled |

## Verification
The bench builds the block with its default parameters: a 6-bit offset and the identifier pair 6003h/1013h. With a 6-bit offset the bench can reach the top offset 63 and a middle offset, and so show that both read as zero. The default identifiers let it check the fixed doubleword against a literal value. The directed tests drive byte enables one lane at a time and clear flags selectively. They also place an error pulse and a clear of the same flag in one cycle, which is where the set-over-clear priority shows.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
    localparam int NUM_ERR = 6;
    localparam logic [15:0] STAT_CONST = 16'h0210;
    localparam logic [15:0] ERR_BITS   = 16'hF900;
    localparam logic [15:0] CMD_RW     = 16'h0146;

    typedef struct packed {
        logic serr;
        logic perr;
        logic master;
        logic mem;
    } cmd_t;

    // place error flags at their status bit positions
    function automatic logic [15:0] err_to_stat(input logic [NUM_ERR-1:0] e);
        return {e[5:1], 2'b00, e[0], 8'h00};
    endfunction

    // pick error flag positions out of a status halfword
    function automatic logic [NUM_ERR-1:0] stat_to_err(input logic [15:0] s);
        return {s[15:11], s[8]};
    endfunction

    function automatic logic [15:0] cmd_to_word(input cmd_t c);
        return {7'b0, c.serr, 1'b0, c.perr, 3'b000, c.master, c.mem, 1'b0};
    endfunction
endpackage

// File: rtl/pcicfg_cmd_reg.sv
module pcicfg_cmd_reg
    import pcicfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lane0,
    input  logic        wr_lane1,
    input  logic [15:0] wdata,
    output cmd_t        cmd_q
);
    cmd_t cmd_d;

    always_comb begin
        cmd_d = cmd_q;
        if (wr_lane0) begin
            cmd_d.perr   = wdata[6];
            cmd_d.master = wdata[2];
            cmd_d.mem    = wdata[1];
        end
        if (wr_lane1) begin
            cmd_d.serr = wdata[8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end
endmodule

// File: rtl/pcicfg_err_reg.sv
module pcicfg_err_reg
    import pcicfg_pkg::*;
#(
    parameter int N = NUM_ERR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] set_bits,
    output logic [N-1:0] err_q
);
    logic [N-1:0] err_d;

    always_comb begin
        err_d = err_q;
        if (clr_en) err_d = err_d & ~clr_bits;
        err_d = err_d | set_bits; // a new error outranks a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end
endmodule

// File: rtl/pcicfg_rd_mux.sv
module pcicfg_rd_mux #(
    parameter int          ADDR_W = 6,
    parameter logic [15:0] DEV_ID = 16'h6003,
    parameter logic [15:0] VEN_ID = 16'h1013
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       cmd_w,
    input  logic [15:0]       status_w,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] OFF_ID = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_CS = ADDR_W'(1);

    always_comb begin
        rdata = '0;
        if (addr == OFF_ID)      rdata = {DEV_ID, VEN_ID};
        else if (addr == OFF_CS) rdata = {status_w, cmd_w};
    end
endmodule

// File: rtl/pcicfg_hdr.sv
module pcicfg_hdr
    import pcicfg_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter logic [15:0] DEV_ID = 16'h6003,
    parameter logic [15:0] VEN_ID = 16'h1013
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [5:0]        err_set,
    output logic              en_serr,
    output logic              en_perr,
    output logic              en_master,
    output logic              en_mem
);
    localparam logic [ADDR_W-1:0] OFF_CS = ADDR_W'(1);

    logic               wr_cs;
    cmd_t               cmd_q;
    logic [NUM_ERR-1:0] err_q;
    logic [15:0]        cmd_w;
    logic [15:0]        status_w;

    assign wr_cs = cfg_wr && (cfg_addr == OFF_CS);

    pcicfg_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lane0 (wr_cs && cfg_be[0]),
        .wr_lane1 (wr_cs && cfg_be[1]),
        .wdata    (cfg_wdata[15:0]),
        .cmd_q    (cmd_q)
    );

    pcicfg_err_reg #(.N(NUM_ERR)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_cs && cfg_be[3]),
        .clr_bits (stat_to_err(cfg_wdata[31:16])),
        .set_bits (err_set),
        .err_q    (err_q)
    );

    assign cmd_w    = cmd_to_word(cmd_q);
    assign status_w = STAT_CONST | err_to_stat(err_q);

    pcicfg_rd_mux #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .VEN_ID(VEN_ID)) u_rd (
        .addr     (cfg_addr),
        .cmd_w    (cmd_w),
        .status_w (status_w),
        .rdata    (cfg_rdata)
    );

    assign en_serr   = cmd_q.serr;
    assign en_perr   = cmd_q.perr;
    assign en_master = cmd_q.master;
    assign en_mem    = cmd_q.mem;
endmodule

// File: rtl/pcicfg_hdr_chk.sv
module pcicfg_hdr_chk
    import pcicfg_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter logic [15:0] DEV_ID = 16'h6003,
    parameter logic [15:0] VEN_ID = 16'h1013
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic [5:0]        err_set,
    input logic [15:0]       cmd_w,
    input logic [15:0]       status_w,
    input logic              en_master
);
    localparam logic [ADDR_W-1:0] OFF_ID = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_CS = ADDR_W'(1);

    p_id_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFF_ID) |-> (cfg_rdata == {DEV_ID, VEN_ID}));

    p_stat_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFF_CS) |-> (cfg_rdata[26:25] == 2'b01 && cfg_rdata[20]
                                  && cfg_rdata[23:21] == 3'b0 && cfg_rdata[19:16] == 4'b0));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == OFF_CS && cfg_be[3]) |=>
        ((status_w & $past(cfg_wdata[31:16] & ERR_BITS & ~err_to_stat(err_set))) == 16'h0));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != 6'h0) |=>
        ((status_w & $past(err_to_stat(err_set))) == $past(err_to_stat(err_set))));

    p_master_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == OFF_CS && cfg_be[0]) |=> (en_master == $past(cfg_wdata[2])));

    p_cmd_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w & ~CMD_RW) == 16'h0);

    p_other_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr != OFF_CS) |=> (cmd_w == $past(cmd_w)));
endmodule

bind pcicfg_hdr pcicfg_hdr_chk #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .VEN_ID(VEN_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .err_set   (err_set),
    .cmd_w     (cmd_w),
    .status_w  (status_w),
    .en_master (en_master)
);

// File: tb/test_pcicfg_hdr.sv
`timescale 1ns/1ps
module test_pcicfg_hdr;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [3:0]    cfg_be = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [5:0]    err_set = '0;
    logic          en_serr, en_perr, en_master, en_mem;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pcicfg_hdr i_pcicfg_hdr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .err_set(err_set), .en_serr(en_serr), .en_perr(en_perr),
        .en_master(en_master), .en_mem(en_mem)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d,
                      input logic [5:0] e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; err_set = e;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; err_set = '0;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk);
        err_set = e;
        @(negedge clk);
        err_set = '0;
    endtask

    function automatic logic [31:0] ens();
        return {28'h0, en_serr, en_perr, en_master, en_mem};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(1, v);
        chk("R2 status/command", v, 32'h0210_0000);
        chk("R2 enables", ens(), 32'h0);
        rd(0, v);
        chk("R1 id word", v, 32'h6003_1013);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(1, 4'b0011, 32'h0000_FFFF, 6'h0);
        rd(1, v);
        chk("R7 cmd ones", {16'h0, v[15:0]}, 32'h0000_0146);
        chk("R6 enables set", ens(), 32'hF);
        chk("R3 fixed status bits", {v[31:16], 16'h0}, 32'h0210_0000);
        wr(1, 4'b0010, 32'h0000_0000, 6'h0);
        rd(1, v);
        chk("R8 lane1 only", {16'h0, v[15:0]}, 32'h0000_0046);
        chk("R6 serr off", ens(), 32'h7);
        wr(1, 4'b0001, 32'h0000_0004, 6'h0);
        rd(1, v);
        chk("R6 master only", {16'h0, v[15:0]}, 32'h0000_0004);
        chk("R6 master output", ens(), 32'h2);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        pulse(6'h3F);
        rd(1, v);
        chk("R5 all flags set", {v[31:16], 16'h0}, 32'hFB10_0000);
        wr(1, 4'b1000, 32'h8800_0000, 6'h0);
        rd(1, v);
        chk("R4 clear 15 and 11", {v[31:16], 16'h0}, 32'h7310_0000);
        wr(1, 4'b1000, 32'h0000_0000, 6'h0);
        rd(1, v);
        chk("R4 zero keeps", {v[31:16], 16'h0}, 32'h7310_0000);
        wr(1, 4'b0100, 32'hFFFF_0000, 6'h0);
        rd(1, v);
        chk("R8 lane3 off", {v[31:16], 16'h0}, 32'h7310_0000);
        wr(1, 4'b1000, 32'hFFFF_0000, 6'h0);
        rd(1, v);
        chk("R4 clear all", {v[31:16], 16'h0}, 32'h0210_0000);
        pulse(6'b000001);
        rd(1, v);
        chk("R5 bit0 to 8", {v[31:16], 16'h0}, 32'h0310_0000);
        wr(1, 4'b1000, 32'hFFFF_0000, 6'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        pulse(6'h3F);
        wr(1, 4'b1000, 32'hFFFF_0000, 6'b100000);
        rd(1, v);
        chk("R5 set beats clear", {v[31:16], 16'h0}, 32'h8210_0000);
        wr(1, 4'b1000, 32'hFFFF_0000, 6'h0);
        rd(1, v);
        chk("R4 later clear", {v[31:16], 16'h0}, 32'h0210_0000);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        rd(2, v);
        chk("R9 offset 2", v, 32'h0);
        rd(63, v);
        chk("R9 offset 63", v, 32'h0);
        wr(5, 4'hF, 32'hFFFF_FFFF, 6'h0);
        rd(5, v);
        chk("R9 offset 5 after write", v, 32'h0);
        rd(1, v);
        chk("R9 state untouched", v, 32'h0210_0004);
    endtask

    task automatic t_id_write();
        logic [31:0] v;
        pulse(6'b000010);
        wr(0, 4'hF, 32'hFFFF_FFFF, 6'h0);
        rd(0, v);
        chk("R10 id unchanged", v, 32'h6003_1013);
        rd(1, v);
        chk("R10 cs unchanged", v, 32'h0A10_0004);
        chk("R10 enables unchanged", ens(), 32'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, all requirements");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_errors();
        t_priority();
        t_unimpl();
        t_id_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule